// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the entry half of exception handling for a small processor core. A request names either an internal fault cause or an external interrupt with its priority level, and supplies both candidate program-counter values. The sequencer then does five things in order:

- rewrites the status register to supervisor state;
- obtains a vector number, either computed from the cause or read back through an interrupt-acknowledge bus cycle;
- pushes a two-word frame onto the single system stack;
- reads the handler address out of a vector table placed by a base register;
- announces the handler start together with the new stack pointer.

The core keeps ownership of its architectural registers. The sequencer reports the new status and stack values through write strobes. It masters a word-wide bus that has a request/acknowledge handshake and a marker for the acknowledge address space. The status register, the stack pointer, the table base and all request fields are captured when the request is accepted. A request that arrives during a sequence is not taken.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `bus_req`, `sr_we`, `sp_we` and `handler_start` are all low.
- R2: A request accepted in idle causes, one cycle later, a single-cycle `sr_we`. `sr_out` is the captured status with bit 13 (supervisor) set and bit 15 (trace) cleared. For an interrupt, bit 12 is also cleared and bits 10:8 take the request level. All other bits are copied unchanged.
- R3: For a fault (`req_irq`=0), the vector number is `req_cause`+2 and no acknowledge cycle runs.
- R4: For an interrupt, the first bus access is a read with `bus_iack`=1 at address 0xFFFFFFE0 + 4×level. The vector number is `bus_rdata[7:0]` when that access is acknowledged.
- R5: If `bus_spurious` is high when the acknowledge cycle completes, the vector number becomes 24.
- R6: The new stack pointer NSP is (`sp_in` with bits 1:0 cleared) − 8. The frame is written in two steps:
  - first, the saved PC is written at NSP;
  - second, the word {2'b01, sp_in[1:0], 2'b00, vector[7:0], 2'b00, captured status[15:0]} is written at NSP+4.
- R7: The saved PC is `req_fault_pc` for fault causes 0–7, and `req_next_pc` for fault causes 8–15 and for all interrupts.
- R8: The handler address is read from {vbr_in[31:20], 10'b0, vector, 2'b00}. The low 20 bits of the base are ignored.
- R9: The cycle after the table read is acknowledged, `handler_start` and `sp_we` pulse together for one cycle. `handler_pc` equals the read data and `sp_out` equals NSP. The block is idle in the following cycle.
- R10: Every bus access holds its address, direction, data and space marker stable until `bus_ack`, and the sequence advances only on `bus_ack`.
- R11: `req_valid` while `busy` is ignored. The running sequence keeps its captured values, and no second sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Exception request |
| req_irq | input | 1 | 1 = interrupt, 0 = internal fault |
| req_cause | input | 4 | Fault cause code |
| req_level | input | 3 | Interrupt priority level |
| req_fault_pc | input | 32 | Address of the faulting instruction |
| req_next_pc | input | 32 | Address of the next instruction |
| sr_in | input | 16 | Current status register |
| sp_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector table base |
| sr_out | output | 16 | New status register value |
| sr_we | output | 1 | Status register write strobe |
| sp_out | output | 32 | New stack pointer value |
| sp_we | output | 1 | Stack pointer write strobe |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write |
| bus_iack | output | 1 | Access is in the acknowledge space |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_spurious | input | 1 | Acknowledge cycle found no source |
| handler_start | output | 1 | Handler fetch begins |
| handler_pc | output | 32 | Handler address |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions check on every cycle the invariants that hold regardless of request contents:
- strobes stay quiet in idle;
- the supervisor and trace bits are correct at the status write;
- acknowledge accesses are reads placed in the acknowledge region;
- stack writes are word aligned;
- a bus access holds steady while waiting;
- the start pulse is single and pairs with the stack write.

The actual values need the bench's scenarios, which vary fault cause, interrupt level, alignment, wait states, spurious responses and requests that arrive mid-sequence. These values are the vector number choice, the PC selection, the frame word layout, the table address and the handler address.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter logic [7:0] SPUR_VEC   = 8'd24,
  parameter logic [7:0] CAUSE_BASE = 8'd2,
  parameter int         FAULT_LIM  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_irq,
  input  logic [3:0]  req_cause,
  input  logic [2:0]  req_level,
  input  logic [31:0] req_fault_pc,
  input  logic [31:0] req_next_pc,
  input  logic [15:0] sr_in,
  input  logic [31:0] sp_in,
  input  logic [31:0] vbr_in,
  output logic [15:0] sr_out,
  output logic        sr_we,
  output logic [31:0] sp_out,
  output logic        sp_we,
  output logic        bus_req,
  output logic        bus_we,
  output logic        bus_iack,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  input  logic        bus_spurious,
  output logic        handler_start,
  output logic [31:0] handler_pc,
  output logic        busy
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SRW, ST_IACK, ST_PUSH_PC, ST_PUSH_HI, ST_FETCH, ST_GO
  } st_t;

  st_t         st;
  logic        irq_q;
  logic [2:0]  lvl_q;
  logic [15:0] sr_q;
  logic [31:0] nsp_q;
  logic [1:0]  mis_q;
  logic [7:0]  vec_q;
  logic [31:0] pc_q;
  logic [11:0] vbase_q;
  logic [31:0] hpc_q;
  logic        unused_vbr;

  assign unused_vbr = ^vbr_in[19:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      irq_q   <= 1'b0;
      lvl_q   <= '0;
      sr_q    <= '0;
      nsp_q   <= '0;
      mis_q   <= '0;
      vec_q   <= '0;
      pc_q    <= '0;
      vbase_q <= '0;
      hpc_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          irq_q   <= req_irq;
          lvl_q   <= req_level;
          sr_q    <= sr_in;
          nsp_q   <= {sp_in[31:2], 2'b00} - 32'd8;
          mis_q   <= sp_in[1:0];
          vec_q   <= CAUSE_BASE + {4'd0, req_cause};
          pc_q    <= (!req_irq && int'(req_cause) < FAULT_LIM) ? req_fault_pc : req_next_pc;
          vbase_q <= vbr_in[31:20];
          st      <= ST_SRW;
        end
        ST_SRW: st <= irq_q ? ST_IACK : ST_PUSH_PC;
        ST_IACK: if (bus_ack) begin
          vec_q <= bus_spurious ? SPUR_VEC : bus_rdata[7:0];
          st    <= ST_PUSH_PC;
        end
        ST_PUSH_PC: if (bus_ack) st <= ST_PUSH_HI;
        ST_PUSH_HI: if (bus_ack) st <= ST_FETCH;
        ST_FETCH: if (bus_ack) begin
          hpc_q <= bus_rdata;
          st    <= ST_GO;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sr_out = irq_q ? {1'b0, sr_q[14], 1'b1, 1'b0, sr_q[11], lvl_q, sr_q[7:0]}
                        : {1'b0, sr_q[14], 1'b1, sr_q[12:0]};
  assign sr_we  = (st == ST_SRW);

  assign bus_iack = (st == ST_IACK);
  assign bus_we   = (st == ST_PUSH_PC) || (st == ST_PUSH_HI);
  assign bus_req  = bus_iack || bus_we || (st == ST_FETCH);

  always_comb begin
    case (st)
      ST_IACK:    bus_addr = {{27{1'b1}}, lvl_q, 2'b00};
      ST_PUSH_PC: bus_addr = nsp_q;
      ST_PUSH_HI: bus_addr = nsp_q + 32'd4;
      ST_FETCH:   bus_addr = {vbase_q, 10'd0, vec_q, 2'b00};
      default:    bus_addr = '0;
    endcase
    case (st)
      ST_PUSH_PC: bus_wdata = pc_q;
      ST_PUSH_HI: bus_wdata = {2'b01, mis_q, 2'b00, vec_q, 2'b00, sr_q};
      default:    bus_wdata = '0;
    endcase
  end

  assign handler_start = (st == ST_GO);
  assign handler_pc    = hpc_q;
  assign sp_we         = (st == ST_GO);
  assign sp_out        = nsp_q;
  assign busy          = (st != ST_IDLE);

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] sr_out,
  input logic        sr_we,
  input logic [31:0] sp_out,
  input logic        sp_we,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_iack,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack,
  input logic        handler_start,
  input logic        busy
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !sr_we && !sp_we && !handler_start));

  a_r2_sr_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> (sr_out[13] && !sr_out[15]));

  a_r2_sr_once: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> !sr_we);

  a_r4_iack_space: assert property (@(posedge clk) disable iff (!rst_n)
    bus_iack |-> (bus_req && !bus_we && bus_addr[31:5] == '1 && bus_addr[1:0] == 2'b00));

  a_r6_aligned_push: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_addr[1:0] == 2'b00));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata) && $stable(bus_iack)));

  a_r9_sp_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    handler_start |-> (sp_we && sp_out[1:0] == 2'b00));

  a_r9_start_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    handler_start |=> (!handler_start && !busy));

endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sr_out(sr_out), .sr_we(sr_we), .sp_out(sp_out),
  .sp_we(sp_we), .bus_req(bus_req), .bus_we(bus_we), .bus_iack(bus_iack),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .handler_start(handler_start), .busy(busy)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_irq = 0;
  logic [3:0]  req_cause = 0;
  logic [2:0]  req_level = 0;
  logic [31:0] req_fault_pc = 0, req_next_pc = 0, sp_in = 0, vbr_in = 0;
  logic [15:0] sr_in = 0;
  logic [15:0] sr_out;
  logic        sr_we, sp_we, bus_req, bus_we, bus_iack, handler_start, busy;
  logic [31:0] sp_out, bus_addr, bus_wdata, handler_pc;
  logic [31:0] bus_rdata = 0;
  logic        bus_ack = 0, bus_spurious = 0;

  exc_entry_seq u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0;

  logic [7:0] plan_vec = 0;
  bit         plan_spur = 0;
  int         nwait = 0, wcnt = 0;

  int          p = 0;
  logic [31:0] q_addr[$], q_wd[$];
  bit          q_we[$], q_iack[$];
  string       q_tag[$];
  logic [15:0] e_sr;
  logic [31:0] e_sp, e_hpc;

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      p = 0;
      cmp_on = 1;
    end else case (p)
      0: if (req_valid) begin
        logic [7:0]  v;
        logic [31:0] nsp, pc, fa;
        e_sr = (sr_in | 16'h2000) & ~16'h8000;
        if (req_irq) e_sr = (e_sr & ~16'h1700) | (16'(req_level) << 8);
        v   = req_irq ? (plan_spur ? 8'd24 : plan_vec) : 8'(req_cause) + 8'd2;
        nsp = (sp_in & ~32'd3) - 32'd8;
        pc  = (!req_irq && req_cause < 8) ? req_fault_pc : req_next_pc;
        fa  = (vbr_in & 32'hFFF0_0000) | (32'(v) << 2);
        e_sp = nsp;
        e_hpc = table_word(fa);
        if (req_irq) begin
          q_addr.push_back(32'hFFFF_FFE0 | (32'(req_level) << 2));
          q_we.push_back(0); q_iack.push_back(1); q_wd.push_back(0); q_tag.push_back("R4");
        end
        q_addr.push_back(nsp); q_we.push_back(1); q_iack.push_back(0);
        q_wd.push_back(pc); q_tag.push_back("R7 R6");
        q_addr.push_back(nsp + 4); q_we.push_back(1); q_iack.push_back(0);
        q_wd.push_back((32'(4 | sp_in[1:0]) << 28) | (32'(v) << 18) | 32'(sr_in));
        q_tag.push_back(req_irq ? (plan_spur ? "R5 R6" : "R4 R6") : "R3 R6");
        q_addr.push_back(fa); q_we.push_back(0); q_iack.push_back(0);
        q_wd.push_back(0); q_tag.push_back("R8");
        p = 1;
      end
      1: p = 2;
      2: if (bus_ack && q_addr.size() > 0) begin
        void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_iack.pop_front());
        void'(q_wd.pop_front()); void'(q_tag.pop_front());
        if (q_addr.size() == 0) p = 3;
      end
      default: p = 0;
    endcase
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      cmp("R1 R11 busy", 32'(busy), 32'(p != 0));
      cmp("R2 sr_we", 32'(sr_we), 32'(p == 1));
      if (p == 1) cmp("R2 sr_out", 32'(sr_out), 32'(e_sr));
      cmp("R10 bus_req", 32'(bus_req), 32'(p == 2));
      if (p == 2 && bus_req && q_addr.size() > 0) begin
        string t;
        t = (wcnt != 0) ? {q_tag[0], " R10"} : q_tag[0];
        cmp(t, bus_addr, q_addr[0]);
        cmp(t, 32'(bus_we), 32'(q_we[0]));
        cmp(t, 32'(bus_iack), 32'(q_iack[0]));
        if (q_we[0]) cmp(t, bus_wdata, q_wd[0]);
      end
      cmp("R9 handler_start", 32'(handler_start), 32'(p == 3));
      cmp("R9 sp_we", 32'(sp_we), 32'(p == 3));
      if (p == 3) begin
        cmp("R9 handler_pc", handler_pc, e_hpc);
        cmp("R9 sp_out", sp_out, e_sp);
      end
    end
    bus_ack = 0;
    bus_spurious = 0;
    if (bus_req) begin
      if (wcnt >= nwait) begin
        bus_ack = 1;
        wcnt = 0;
        if (bus_iack) begin
          bus_rdata = {24'hC0FFEE, plan_vec};
          bus_spurious = plan_spur;
        end else bus_rdata = table_word(bus_addr);
      end else wcnt++;
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  task automatic run(input bit irq, input logic [3:0] cause, input logic [2:0] lvl,
                     input logic [31:0] fpc, npc, input logic [15:0] sr,
                     input logic [31:0] sp, vbr, input logic [7:0] ivec,
                     input bit spur, input int waits, input bit poke);
    @(negedge clk);
    nwait = waits; plan_vec = ivec; plan_spur = spur;
    req_irq = irq; req_cause = cause; req_level = lvl; req_fault_pc = fpc;
    req_next_pc = npc; sr_in = sr; sp_in = sp; vbr_in = vbr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      // R11: new request and changed core state while busy
      req_valid = 1; req_irq = ~irq; req_cause = ~cause; req_level = ~lvl;
      sr_in = ~sr; sp_in = sp + 32'h100; vbr_in = ~vbr;
      req_fault_pc = ~fpc; req_next_pc = ~npc;
      repeat (3) @(negedge clk);
      req_valid = 0;
    end
    for (int i = 0; i < 200 && p != 0; i++) @(negedge clk);
    cmp("R11 back to idle", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset busy", 32'(busy), 0);
    cmp("R1 reset bus_req", 32'(bus_req), 0);
    cmp("R1 reset handler_start", 32'(handler_start), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 4'd3,  3'd0, 32'h0000_1000, 32'h0000_1004, 16'h8704, 32'h0040_0000, 32'h1230_0000, 8'h00, 0, 0, 0);
    run(0, 4'd12, 3'd0, 32'h0000_2000, 32'h0000_2002, 16'h0011, 32'h0040_0102, 32'hABC0_0000, 8'h00, 0, 2, 0);
    run(1, 4'd0,  3'd5, 32'h0000_3000, 32'h0000_3008, 16'h9F00, 32'h0080_0001, 32'h0010_0000, 8'h47, 0, 1, 0);
    run(1, 4'd0,  3'd7, 32'h0000_4000, 32'h0000_4006, 16'h1300, 32'h0080_0010, 32'hFFF0_0000, 8'h99, 1, 0, 0);
    run(1, 4'd0,  3'd1, 32'h0000_5000, 32'h0000_5004, 16'h2000, 32'h00C0_0000, 32'h2000_0000, 8'hFF, 0, 3, 1);
    run(0, 4'd0,  3'd0, 32'h0000_6000, 32'h0000_6002, 16'hFFFF, 32'h0000_0013, 32'h345F_FFFF, 8'h00, 0, 0, 0);
    run(0, 4'd7,  3'd0, 32'h0000_7000, 32'h0000_7004, 16'h0000, 32'h0000_0F08, 32'h0000_0000, 8'h00, 0, 1, 1);
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule